// File: doc/BRIEF.md
# Single-Owner Directory Home Controller

This block is the home node for a range of memory lines under a single-owner coherence scheme. For every line it keeps a state, an owner vector and a stored copy of the line. Caches send fetches on a request channel and send clean-eviction acks or dirty writebacks on a response channel. A DMA engine uses the request channel to read whole lines and to write a byte range inside a line. The block issues reads and writebacks on a memory command port. It consumes memory completions and returns data, acks and invalidations on one outbound message port.

When a DMA access targets a line that a cache owns, the owner is invalidated first. The controller waits for the owner's writeback. On a DMA read it forwards that data to the DMA engine; on a DMA write it merges the DMA bytes into that data. Memory is updated before the line becomes idle again. A small buffer holds the pending DMA writes that are waiting on an owner. Any request that would disturb a line in a transient state is stalled at the channel, so it stays in place until the line settles.

Top module: `line_home_ctrl`

## Requirements
- R1: After reset every line is idle with no owner, `out_valid_o` and `mem_req_valid_o` are low, a fetch to any line is ready, and a response to any line is not ready.
- R2: A fetch (request type 0 read-shared, 1 instruction fetch or 2 read-exclusive) to an idle line issues a memory read (`mem_req_wr_o`=0) tagged with the requestor. The read completion sends an outbound message of type 0 (clean data) to the tag, carrying the completion data, and the requestor becomes the single owner.
- R3: A clean-eviction ack (`rsp_dirty_i`=0) from the owner of a line sends a type 1 ack to that sender, clears the owner and makes the line idle.
- R4: Dirty writeback data (`rsp_dirty_i`=1) to an owned line replaces the stored line and issues a memory writeback (`mem_req_wr_o`=1) with that data, tagged with the sender. The writeback completion sends a type 1 ack to the tag and makes the line idle.
- R5: A DMA read (type 3) to an idle line issues a memory read tagged with `HOME_ID`. The completion sends the full line to `DMA_ID` as a type 3 message.
- R6: A DMA write (type 4) to an idle line replaces bytes `off` to `off+len-1` (byte b at bits 8b+7:8b, bytes past the line end dropped, len 0 writes nothing) of the stored line. It issues a writeback of the merged line tagged `HOME_ID`, and the completion sends a type 4 ack to `DMA_ID`.
- R7: A DMA read to an owned line sends a type 2 invalidate to the owner. The owner's writeback data is sent to `DMA_ID` as type 3 and written back to memory in the same cycle. After the memory ack the line is idle and accepts a new fetch.
- R8: A DMA write to an owned line is buffered and a type 2 invalidate goes to the owner. The owner's writeback is merged with the buffered bytes, stored and written back. The memory ack sends a type 4 ack to `DMA_ID` and makes the line idle.
- R9: A fetch to a line that is not idle, a DMA request to a line in a transient state, and a dirty writeback to a line not awaiting one are held with ready low.
- R10: A latency-1 message or command is valid from the first cycle after the accepting edge. An invalidate is valid `INV_LAT`-1 cycles later than that (6 accepting-edge-to-valid cycles by default).
- R11: When an acceptable response and an acceptable request are offered in the same cycle, only the response is accepted.
- R12: With `PEND` DMA writes already waiting on owners, a further DMA write to an owned line is held.
- R13: While an outbound message or memory command is not accepted, it stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_type_i | input | 3 | 0/1/2 fetch, 3 DMA read, 4 DMA write |
| req_line_i | input | LINE_W | Line index |
| req_src_i | input | ID_W | Requestor id |
| req_off_i | input | OFF_W | DMA write start byte |
| req_len_i | input | LEN_W | DMA write byte count |
| req_data_i | input | DW | DMA write bytes, line-aligned |
| rsp_valid_i | input | 1 | Response offered |
| rsp_ready_o | output | 1 | Response accepted this cycle |
| rsp_dirty_i | input | 1 | 1 dirty writeback data, 0 clean ack |
| rsp_line_i | input | LINE_W | Line index |
| rsp_src_i | input | ID_W | Sending cache |
| rsp_data_i | input | DW | Writeback data |
| mem_req_valid_o | output | 1 | Memory command valid |
| mem_req_ready_i | input | 1 | Memory command taken |
| mem_req_wr_o | output | 1 | 1 writeback, 0 read |
| mem_req_line_o | output | LINE_W | Line index |
| mem_req_tag_o | output | ID_W | Originator tag |
| mem_req_data_o | output | DW | Writeback data |
| mem_rsp_valid_i | input | 1 | Memory completion offered |
| mem_rsp_ready_o | output | 1 | Completion accepted |
| mem_rsp_wr_i | input | 1 | 1 writeback ack, 0 read data |
| mem_rsp_line_i | input | LINE_W | Line index |
| mem_rsp_tag_i | input | ID_W | Echoed tag |
| mem_rsp_data_i | input | DW | Read data |
| out_valid_o | output | 1 | Outbound message valid |
| out_ready_i | input | 1 | Outbound message taken |
| out_type_o | output | 3 | 0 data, 1 ack, 2 invalidate, 3 DMA data, 4 DMA ack |
| out_dst_o | output | ID_W | Destination id |
| out_line_o | output | LINE_W | Line index |
| out_data_o | output | DW | Payload |

## Verification
The partial-write merge is tried with a table of offset and length pairs: a full line, interior ranges, the last byte, zero length and a range running past the line end. Each pair is read back through a DMA read, which separates off-by-one byte selection from clipping errors. Fetches are tried with all three fetch types and with different requestors, which shows that the tag, rather than a fixed id, steers the data. DMA reads and writes are each tried on idle and on owned lines, which exposes whether the invalidate, forward and merge paths are taken only when an owner exists. The stored line is then probed with a zero-length DMA write, whose writeback shows what the directory kept.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [3:0] {
    ST_I, ST_M, ST_IM, ST_MI, ST_ID, ST_IDW,
    ST_MDRD, ST_MDRDI, ST_MDWR, ST_MDWRI
  } line_st_e;

  typedef enum logic [2:0] {
    RQ_RDS = 3'd0, RQ_IFT = 3'd1, RQ_RDX = 3'd2, RQ_DRD = 3'd3, RQ_DWR = 3'd4
  } req_e;

  typedef enum logic [2:0] {
    OT_DATA = 3'd0, OT_ACK = 3'd1, OT_INV = 3'd2, OT_DDATA = 3'd3, OT_DACK = 3'd4
  } out_e;
endpackage

// File: rtl/hc_merge.sv
module hc_merge #(
  parameter int BYTES = 8,
  parameter int OFF_W = 3,
  parameter int LEN_W = 4
) (
  input  logic [BYTES*8-1:0] base_i,
  input  logic [BYTES*8-1:0] wr_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic [BYTES*8-1:0] res_o
);
  localparam int E_W = LEN_W + 1;
  logic [E_W-1:0] end_w;
  assign end_w = E_W'(off_i) + E_W'(len_i);

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam logic [E_W-1:0] BIDX = E_W'(b);
    logic sel;
    assign sel = (BIDX >= E_W'(off_i)) && (BIDX < end_w);
    assign res_o[b*8 +: 8] = sel ? wr_i[b*8 +: 8] : base_i[b*8 +: 8];
  end
endmodule

// File: rtl/hc_slot.sv
module hc_slot #(
  parameter int W     = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] lat_i,
  input  logic [W-1:0]     data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             busy_o,
  output logic [W-1:0]     data_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_i;
      data_q <= data_i;
    end else if (busy_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (ready_i) busy_q <= 1'b0;
    end
  end

  assign valid_o = busy_q && (cnt_q == '0);
  assign busy_o  = busy_q;
  assign data_o  = data_q;

  // R13
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
  // R10
  slot_no_clobber_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
endmodule

// File: rtl/hc_pend.sv
module hc_pend #(
  parameter int ENTRIES = 2,
  parameter int LINE_W  = 4,
  parameter int OFF_W   = 3,
  parameter int LEN_W   = 4,
  parameter int DW      = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] a_line_i,
  input  logic [OFF_W-1:0]  a_off_i,
  input  logic [LEN_W-1:0]  a_len_i,
  input  logic [DW-1:0]     a_data_i,
  output logic              full_o,
  input  logic [LINE_W-1:0] look_line_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  h_off_o,
  output logic [LEN_W-1:0]  h_len_o,
  output logic [DW-1:0]     h_data_o,
  input  logic              free_i
);
  logic [ENTRIES-1:0] vld_q, hit_v, free_v;
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [OFF_W-1:0]   off_q  [ENTRIES];
  logic [LEN_W-1:0]   len_q  [ENTRIES];
  logic [DW-1:0]      data_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_hit
    assign hit_v[e] = vld_q[e] && (line_q[e] == look_line_i);
  end

  always_comb begin
    logic taken;
    taken    = 1'b0;
    free_v   = '0;
    h_off_o  = '0;
    h_len_o  = '0;
    h_data_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!vld_q[e] && !taken) begin
        free_v[e] = 1'b1;
        taken     = 1'b1;
      end
      if (hit_v[e]) begin
        h_off_o  = off_q[e];
        h_len_o  = len_q[e];
        h_data_o = data_q[e];
      end
    end
  end

  assign full_o = &vld_q;
  assign hit_o  = |hit_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        line_q[e] <= '0;
        off_q[e]  <= '0;
        len_q[e]  <= '0;
        data_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (alloc_i && free_v[e]) begin
          vld_q[e]  <= 1'b1;
          line_q[e] <= a_line_i;
          off_q[e]  <= a_off_i;
          len_q[e]  <= a_len_i;
          data_q[e] <= a_data_i;
        end else if (free_i && hit_v[e]) begin
          vld_q[e] <= 1'b0;
        end
      end
    end
  end

  // R12
  pend_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  // R8
  pend_free_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> hit_o);
endmodule

// File: rtl/line_home_ctrl.sv
module line_home_ctrl
  import hc_pkg::*;
#(
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 8,
  parameter int NODES      = 4,
  parameter int ID_W       = 3,
  parameter int DMA_ID     = 4,
  parameter int HOME_ID    = 7,
  parameter int PEND       = 2,
  parameter int INV_LAT    = 6,
  parameter int MSG_LAT    = 1,
  localparam int LINE_W = $clog2(LINES),
  localparam int DW     = LINE_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LEN_W  = $clog2(LINE_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_type_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [ID_W-1:0]   req_src_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [DW-1:0]     req_data_i,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic              rsp_dirty_i,
  input  logic [LINE_W-1:0] rsp_line_i,
  input  logic [ID_W-1:0]   rsp_src_i,
  input  logic [DW-1:0]     rsp_data_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_wr_o,
  output logic [LINE_W-1:0] mem_req_line_o,
  output logic [ID_W-1:0]   mem_req_tag_o,
  output logic [DW-1:0]     mem_req_data_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic              mem_rsp_wr_i,
  input  logic [LINE_W-1:0] mem_rsp_line_i,
  input  logic [ID_W-1:0]   mem_rsp_tag_i,
  input  logic [DW-1:0]     mem_rsp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [2:0]        out_type_o,
  output logic [ID_W-1:0]   out_dst_o,
  output logic [LINE_W-1:0] out_line_o,
  output logic [DW-1:0]     out_data_o
);
  localparam int CNT_W = $clog2(INV_LAT + 1);
  localparam int OW    = 3 + ID_W + LINE_W + DW;
  localparam int MW    = 1 + LINE_W + ID_W + DW;
  localparam logic [ID_W-1:0] DMA_D  = ID_W'(DMA_ID);
  localparam logic [ID_W-1:0] HOME_D = ID_W'(HOME_ID);

  line_st_e         st_q  [LINES];
  logic [NODES-1:0] own_q [LINES];
  logic [DW-1:0]    dat_q [LINES];

  function automatic logic [ID_W-1:0] oh2idx(input logic [NODES-1:0] oh);
    oh2idx = '0;
    for (int n = 0; n < NODES; n++) if (oh[n]) oh2idx = ID_W'(n);
  endfunction

  logic out_busy, mem_busy, idle;
  logic mrsp_fire, rsp_fire, req_fire, rsp_ok, req_ok;
  logic is_fetch, pend_full, pend_hit;
  line_st_e req_st, rsp_st;
  logic [LINE_W-1:0] ev_line;
  logic [OFF_W-1:0]  h_off, m_off;
  logic [LEN_W-1:0]  h_len, m_len;
  logic [DW-1:0]     h_data, m_base, m_wr, merged;

  assign idle     = !out_busy && !mem_busy;
  assign req_st   = st_q[req_line_i];
  assign rsp_st   = st_q[rsp_line_i];
  assign is_fetch = req_type_i <= 3'(RQ_RDX);

  assign rsp_ok = rsp_dirty_i ? (rsp_st == ST_M || rsp_st == ST_MDRD || rsp_st == ST_MDWR)
                              : (rsp_st == ST_M);
  always_comb begin
    if (is_fetch)                     req_ok = (req_st == ST_I);
    else if (req_type_i == RQ_DRD)    req_ok = (req_st == ST_I) || (req_st == ST_M);
    else if (req_type_i == RQ_DWR)    req_ok = (req_st == ST_I) || (req_st == ST_M && !pend_full);
    else                              req_ok = 1'b0;
  end

  // memory completions first, then responses, then requests
  assign mem_rsp_ready_o = idle;
  assign mrsp_fire       = idle && mem_rsp_valid_i;
  assign rsp_ready_o     = idle && !mem_rsp_valid_i && rsp_ok;
  assign rsp_fire        = rsp_ready_o && rsp_valid_i;
  assign req_ready_o     = idle && !mem_rsp_valid_i && !(rsp_valid_i && rsp_ok) && req_ok;
  assign req_fire        = req_ready_o && req_valid_i;
  assign ev_line = mrsp_fire ? mem_rsp_line_i : (rsp_fire ? rsp_line_i : req_line_i);

  assign m_base = rsp_fire ? rsp_data_i : dat_q[req_line_i];
  assign m_wr   = rsp_fire ? h_data : req_data_i;
  assign m_off  = rsp_fire ? h_off : req_off_i;
  assign m_len  = rsp_fire ? h_len : req_len_i;

  hc_merge #(.BYTES(LINE_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)) i_merge (
    .base_i(m_base), .wr_i(m_wr), .off_i(m_off), .len_i(m_len), .res_o(merged));

  logic st_we, own_we, dat_we, out_ld, mem_ld, p_alloc, p_free;
  line_st_e st_nxt;
  logic [NODES-1:0] own_nxt;
  logic [DW-1:0]    dat_nxt;
  logic [CNT_W-1:0] out_lat;
  logic [OW-1:0]    out_d, out_q;
  logic [MW-1:0]    mem_d, mem_q;

  always_comb begin
    st_we = 1'b0; st_nxt = ST_I; own_we = 1'b0; own_nxt = '0;
    dat_we = 1'b0; dat_nxt = '0; out_ld = 1'b0; mem_ld = 1'b0;
    out_lat = CNT_W'(MSG_LAT - 1); out_d = '0; mem_d = '0;
    p_alloc = 1'b0; p_free = 1'b0;
    if (mrsp_fire) begin
      case (st_q[mem_rsp_line_i])
        ST_IM: if (!mem_rsp_wr_i) begin
          out_ld = 1'b1; out_d = {OT_DATA, mem_rsp_tag_i, mem_rsp_line_i, mem_rsp_data_i};
          st_we = 1'b1; st_nxt = ST_M;
          own_we = 1'b1; own_nxt = NODES'(1) << mem_rsp_tag_i;
        end
        ST_ID: if (!mem_rsp_wr_i) begin
          out_ld = 1'b1; out_d = {OT_DDATA, DMA_D, mem_rsp_line_i, mem_rsp_data_i};
          st_we = 1'b1; own_we = 1'b1;
        end
        ST_MI: if (mem_rsp_wr_i) begin
          out_ld = 1'b1; out_d = {OT_ACK, mem_rsp_tag_i, mem_rsp_line_i, DW'(0)};
          st_we = 1'b1; own_we = 1'b1;
        end
        ST_IDW, ST_MDWRI: if (mem_rsp_wr_i) begin
          out_ld = 1'b1; out_d = {OT_DACK, DMA_D, mem_rsp_line_i, DW'(0)};
          st_we = 1'b1; own_we = 1'b1;
          p_free = (st_q[mem_rsp_line_i] == ST_MDWRI);
        end
        ST_MDRDI: if (mem_rsp_wr_i) begin
          st_we = 1'b1; own_we = 1'b1;
        end
        default: ;
      endcase
    end else if (rsp_fire) begin
      st_we = 1'b1;
      if (rsp_st == ST_M && !rsp_dirty_i) begin
        out_ld = 1'b1; out_d = {OT_ACK, rsp_src_i, rsp_line_i, DW'(0)};
        own_we = 1'b1;
      end else begin
        dat_we = 1'b1; mem_ld = 1'b1;
        dat_nxt = (rsp_st == ST_MDWR) ? merged : rsp_data_i;
        mem_d = {1'b1, rsp_line_i, rsp_src_i, dat_nxt};
        st_nxt = (rsp_st == ST_M) ? ST_MI : (rsp_st == ST_MDRD) ? ST_MDRDI : ST_MDWRI;
        if (rsp_st == ST_MDRD) begin
          out_ld = 1'b1; out_d = {OT_DDATA, DMA_D, rsp_line_i, rsp_data_i};
        end
      end
    end else if (req_fire) begin
      st_we = 1'b1;
      if (is_fetch) begin
        mem_ld = 1'b1; mem_d = {1'b0, req_line_i, req_src_i, DW'(0)}; st_nxt = ST_IM;
      end else if (req_st == ST_M) begin
        out_ld = 1'b1; out_lat = CNT_W'(INV_LAT - 1);
        out_d = {OT_INV, oh2idx(own_q[req_line_i]), req_line_i, DW'(0)};
        p_alloc = (req_type_i == RQ_DWR);
        st_nxt = p_alloc ? ST_MDWR : ST_MDRD;
      end else if (req_type_i == RQ_DRD) begin
        mem_ld = 1'b1; mem_d = {1'b0, req_line_i, HOME_D, DW'(0)}; st_nxt = ST_ID;
      end else begin
        dat_we = 1'b1; dat_nxt = merged;
        mem_ld = 1'b1; mem_d = {1'b1, req_line_i, HOME_D, merged}; st_nxt = ST_IDW;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) begin
        st_q[l]  <= ST_I;
        own_q[l] <= '0;
        dat_q[l] <= '0;
      end
    end else begin
      if (st_we)  st_q[ev_line]  <= st_nxt;
      if (own_we) own_q[ev_line] <= own_nxt;
      if (dat_we) dat_q[ev_line] <= dat_nxt;
    end
  end

  hc_pend #(.ENTRIES(PEND), .LINE_W(LINE_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .DW(DW)) i_pend (
    .clk_i, .rst_ni, .alloc_i(p_alloc), .a_line_i(req_line_i), .a_off_i(req_off_i),
    .a_len_i(req_len_i), .a_data_i(req_data_i), .full_o(pend_full), .look_line_i(ev_line),
    .hit_o(pend_hit), .h_off_o(h_off), .h_len_o(h_len), .h_data_o(h_data), .free_i(p_free));

  hc_slot #(.W(OW), .CNT_W(CNT_W)) i_out_slot (
    .clk_i, .rst_ni, .load_i(out_ld), .lat_i(out_lat), .data_i(out_d), .ready_i(out_ready_i),
    .valid_o(out_valid_o), .busy_o(out_busy), .data_o(out_q));

  hc_slot #(.W(MW), .CNT_W(CNT_W)) i_mem_slot (
    .clk_i, .rst_ni, .load_i(mem_ld), .lat_i(CNT_W'(MSG_LAT - 1)), .data_i(mem_d),
    .ready_i(mem_req_ready_i), .valid_o(mem_req_valid_o), .busy_o(mem_busy), .data_o(mem_q));

  assign {out_type_o, out_dst_o, out_line_o, out_data_o}               = out_q;
  assign {mem_req_wr_o, mem_req_line_o, mem_req_tag_o, mem_req_data_o} = mem_q;

  // R2
  own_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_st == ST_M |-> $onehot(own_q[req_line_i]));
  // R3
  own_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_st == ST_I |-> own_q[req_line_i] == '0);
  // R11
  rsp_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && rsp_ready_o |-> !req_ready_o);
  // R8
  dwr_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fire && rsp_st == ST_MDWR |-> pend_hit);
endmodule

// File: tb/test_line_home_ctrl.sv
module test_line_home_ctrl;
  localparam int DMA = 4, HOME = 7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic req_valid_i = 0, req_ready_o, rsp_valid_i = 0, rsp_ready_o, rsp_dirty_i = 0;
  logic [2:0] req_type_i = 0, out_type_o;
  logic [3:0] req_line_i = 0, rsp_line_i = 0, mem_req_line_o, mem_rsp_line_i = 0, out_line_o;
  logic [2:0] req_src_i = 0, rsp_src_i = 0, mem_req_tag_o, mem_rsp_tag_i = 0, out_dst_o, req_off_i = 0;
  logic [3:0] req_len_i = 0;
  logic [63:0] req_data_i = 0, rsp_data_i = 0, mem_req_data_o, mem_rsp_data_i = 0, out_data_o;
  logic mem_req_valid_o, mem_req_ready_i = 1, mem_req_wr_o, mem_rsp_valid_i = 0, mem_rsp_ready_o;
  logic mem_rsp_wr_i = 0, out_valid_o, out_ready_i = 1;

  line_home_ctrl i_line_home_ctrl (.*);

  int n_chk = 0, n_bad = 0, w;
  logic [63:0] dir_m [16];
  logic [127:0] hold;

  localparam logic [74:0] VEC [6] = '{
    {4'd1, 3'd0, 4'd8, 64'h1122334455667788},
    {4'd1, 3'd2, 4'd3, 64'hA0A1A2A3A4A5A6A7},
    {4'd2, 3'd7, 4'd1, 64'hFF00000000000000},
    {4'd2, 3'd0, 4'd0, 64'hDEADBEEFDEADBEEF},
    {4'd3, 3'd5, 4'd8, 64'hC1C2C3C4C5C6C7C8},
    {4'd1, 3'd4, 4'd4, 64'h0F0E0D0C0B0A0908}};

  function automatic logic [63:0] bmerge(logic [63:0] b, logic [63:0] d, int off, int len);
    for (int i = 0; i < 8; i++) if (i >= off && i < off + len) b[i*8 +: 8] = d[i*8 +: 8];
    return b;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push_req(input logic [2:0] t, input logic [3:0] ln, input logic [2:0] s,
                          input logic [2:0] off, input logic [3:0] len, input logic [63:0] d);
    @(negedge clk_i);
    req_type_i = t; req_line_i = ln; req_src_i = s; req_off_i = off; req_len_i = len;
    req_data_i = d; req_valid_i = 1;
    forever begin #1; if (req_ready_o) break; @(negedge clk_i); end
    @(posedge clk_i); #1 req_valid_i = 0;
  endtask

  task automatic push_rsp(input logic dirty, input logic [3:0] ln, input logic [2:0] s, input logic [63:0] d);
    @(negedge clk_i);
    rsp_dirty_i = dirty; rsp_line_i = ln; rsp_src_i = s; rsp_data_i = d; rsp_valid_i = 1;
    forever begin #1; if (rsp_ready_o) break; @(negedge clk_i); end
    @(posedge clk_i); #1 rsp_valid_i = 0;
  endtask

  task automatic push_mrsp(input logic wr, input logic [3:0] ln, input logic [2:0] tg, input logic [63:0] d);
    @(negedge clk_i);
    mem_rsp_wr_i = wr; mem_rsp_line_i = ln; mem_rsp_tag_i = tg; mem_rsp_data_i = d; mem_rsp_valid_i = 1;
    forever begin #1; if (mem_rsp_ready_o) break; @(negedge clk_i); end
    @(posedge clk_i); #1 mem_rsp_valid_i = 0;
  endtask

  task automatic out_expect(input logic [2:0] t, input logic [2:0] dst, input logic [3:0] ln,
                            input logic [63:0] d, input string r, output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!out_valid_o && n < 100);
    chk(out_valid_o && {out_type_o, out_dst_o, out_line_o, out_data_o} == {t, dst, ln, d}, r,
        {out_valid_o, out_type_o, out_dst_o, out_line_o, out_data_o}, {1'b1, t, dst, ln, d});
  endtask

  task automatic mem_expect(input logic wr, input logic [3:0] ln, input logic [2:0] tg,
                            input logic [63:0] d, input string r, output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!mem_req_valid_o && n < 100);
    chk(mem_req_valid_o && {mem_req_wr_o, mem_req_line_o, mem_req_tag_o, mem_req_data_o} == {wr, ln, tg, d}, r,
        {mem_req_valid_o, mem_req_wr_o, mem_req_line_o, mem_req_tag_o, mem_req_data_o}, {1'b1, wr, ln, tg, d});
  endtask

  task automatic own_line(input logic [3:0] ln, input logic [2:0] s, input logic [2:0] t, input logic [63:0] d);
    push_req(t, ln, s, 0, 0, 0);
    mem_expect(0, ln, s, 0, "R2", w);
    push_mrsp(0, ln, s, d);
    out_expect(0, s, ln, d, "R2", w);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) dir_m[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    #1;
    chk(!out_valid_o && !mem_req_valid_o, "R1", {out_valid_o, mem_req_valid_o}, 0);
    chk(req_ready_o && !rsp_ready_o, "R1", {req_ready_o, rsp_ready_o}, 2);

    // table: DMA write then DMA read on idle lines
    for (int v = 0; v < 6; v++) begin
      logic [3:0] ln; logic [63:0] e;
      ln = VEC[v][74:71];
      e = bmerge(dir_m[ln], VEC[v][63:0], int'(VEC[v][70:68]), int'(VEC[v][67:64]));
      dir_m[ln] = e;
      push_req(4, ln, 0, VEC[v][70:68], VEC[v][67:64], VEC[v][63:0]);
      mem_expect(1, ln, HOME, e, "R6", w);
      if (v == 0) chk(w == 1, "R10", w, 1);
      push_mrsp(1, ln, HOME, 0);
      out_expect(4, DMA, ln, 0, "R6", w);
      push_req(3, ln, 0, 0, 0, 0);
      mem_expect(0, ln, HOME, 0, "R5", w);
      push_mrsp(0, ln, HOME, e);
      out_expect(3, DMA, ln, e, "R5", w);
    end

    // fetch, stall, clean eviction, refetch, dirty writeback
    push_req(0, 5, 2, 0, 0, 0);
    mem_expect(0, 5, 2, 0, "R2", w);
    @(negedge clk_i); req_type_i = 0; req_line_i = 5; req_valid_i = 1;
    #1 chk(!req_ready_o, "R9", req_ready_o, 0);
    req_type_i = 3;
    #1 chk(!req_ready_o, "R9", req_ready_o, 0);
    req_valid_i = 0;
    push_mrsp(0, 5, 2, 64'h5555_0000_1111_2222);
    out_expect(0, 2, 5, 64'h5555_0000_1111_2222, "R2", w);
    push_rsp(0, 5, 2, 0);
    out_expect(1, 2, 5, 0, "R3", w);
    own_line(5, 1, 1, 64'h0123_4567_89AB_CDEF);
    push_rsp(1, 5, 1, 64'hCAFE_F00D_0000_0001);
    mem_expect(1, 5, 1, 64'hCAFE_F00D_0000_0001, "R4", w);
    push_mrsp(1, 5, 1, 0);
    out_expect(1, 1, 5, 0, "R4", w);
    push_req(4, 5, 0, 0, 1, 64'h77);
    mem_expect(1, 5, HOME, bmerge(64'hCAFE_F00D_0000_0001, 64'h77, 0, 1), "R4", w);
    push_mrsp(1, 5, HOME, 0);
    out_expect(4, DMA, 5, 0, "R6", w);

    // DMA read to an owned line
    own_line(6, 3, 2, 64'h3333);
    push_req(3, 6, 0, 0, 0, 0);
    out_expect(2, 3, 6, 0, "R7", w);
    chk(w == 6, "R10", w, 6);
    @(negedge clk_i); req_type_i = 4; req_line_i = 6; req_valid_i = 1;
    rsp_valid_i = 1; rsp_dirty_i = 1; rsp_line_i = 5;
    #1 chk(!req_ready_o && !rsp_ready_o, "R9", {req_ready_o, rsp_ready_o}, 0);
    req_valid_i = 0; rsp_valid_i = 0;
    push_rsp(1, 6, 3, 64'h6666_AAAA);
    out_expect(3, DMA, 6, 64'h6666_AAAA, "R7", w);
    chk(mem_req_valid_o && {mem_req_wr_o, mem_req_tag_o, mem_req_data_o} == {1'b1, 3'd3, 64'h6666_AAAA}, "R7",
        {mem_req_valid_o, mem_req_wr_o, mem_req_tag_o, mem_req_data_o}, {2'b11, 3'd3, 64'h6666_AAAA});
    push_mrsp(1, 6, 3, 0);
    own_line(6, 1, 0, 64'h4444);

    // DMA writes to owned lines, buffer full, response priority
    own_line(7, 0, 0, 64'h7);
    own_line(8, 0, 2, 64'h8);
    push_req(4, 7, 0, 2, 2, 64'h00000000_BBAA0000);
    out_expect(2, 0, 7, 0, "R8", w);
    push_req(4, 8, 0, 5, 3, 64'hEEDDCC00_00000000);
    out_expect(2, 0, 8, 0, "R8", w);
    @(negedge clk_i); req_type_i = 4; req_line_i = 6; req_valid_i = 1;
    #1 chk(!req_ready_o, "R12", req_ready_o, 0);
    req_valid_i = 0;
    @(negedge clk_i);
    rsp_valid_i = 1; rsp_dirty_i = 1; rsp_line_i = 7; rsp_src_i = 0; rsp_data_i = 64'h1111_2222_3333_4444;
    req_valid_i = 1; req_type_i = 0; req_line_i = 9; req_src_i = 2;
    #1 chk(rsp_ready_o && !req_ready_o, "R11", {rsp_ready_o, req_ready_o}, 2);
    @(posedge clk_i); #1 rsp_valid_i = 0;
    mem_expect(1, 7, 0, bmerge(64'h1111_2222_3333_4444, 64'h00000000_BBAA0000, 2, 2), "R8", w);
    forever begin #1; if (req_ready_o) break; @(negedge clk_i); end
    @(posedge clk_i); #1 req_valid_i = 0;
    mem_expect(0, 9, 2, 0, "R11", w);
    push_mrsp(0, 9, 2, 64'h9);
    out_expect(0, 2, 9, 64'h9, "R2", w);
    push_mrsp(1, 7, 0, 0);
    out_expect(4, DMA, 7, 0, "R8", w);
    push_req(4, 7, 0, 0, 0, 0);
    mem_expect(1, 7, HOME, bmerge(64'h1111_2222_3333_4444, 64'h00000000_BBAA0000, 2, 2), "R8", w);
    push_mrsp(1, 7, HOME, 0);
    out_expect(4, DMA, 7, 0, "R6", w);

    // backpressure on the memory port
    mem_req_ready_i = 0;
    push_rsp(1, 8, 0, 64'h8888_9999_AAAA_BBBB);
    @(negedge clk_i);
    hold = {mem_req_valid_o, mem_req_wr_o, mem_req_line_o, mem_req_tag_o, mem_req_data_o};
    repeat (3) @(negedge clk_i);
    chk(hold[71] && hold == {mem_req_valid_o, mem_req_wr_o, mem_req_line_o, mem_req_tag_o, mem_req_data_o},
        "R13", {mem_req_valid_o, mem_req_wr_o, mem_req_line_o, mem_req_tag_o, mem_req_data_o}, hold);
    mem_req_ready_i = 1;
    chk(hold[63:0] == bmerge(64'h8888_9999_AAAA_BBBB, 64'hEEDDCC00_00000000, 5, 3), "R8",
        hold[63:0], bmerge(64'h8888_9999_AAAA_BBBB, 64'hEEDDCC00_00000000, 5, 3));
    @(posedge clk_i);
    push_mrsp(1, 8, 0, 0);
    out_expect(4, DMA, 8, 0, "R8", w);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule